// File: doc/BRIEF.md
# Receive Line Bit-Width Meter

This block times one low pulse on an asynchronous serial receive line so that software can pick a bitrate. Software arms it. The first falling edge on the line after arming starts a count of master-clock cycles. The rising edge that follows ends the count, stores the result and raises a completion flag. The master-clock frequency divided by the stored count gives the bitrate of the line.

A two-bit status code reports where the meter is:

- 0: not yet initialised after reset.
- 1: ready.
- 2: counting.

The arm bit clears itself when a measurement completes. Clearing the arm bit while a count is running does not stop the count, so the completion event can still happen. Software recovers from an unexpected state by setting the arm bit again, which always restarts the meter from the ready state.

The completion flag is cleared by writing 1 to it. Masked by an enable bit, the flag is merged into the interrupt line that the rest of the receive path shares.

Top module: `abr_meas_unit`

## Requirements
- R1: After reset the status is 0, the arm bit is 0, the stored count is 0, the completion flag is 0 and both interrupt outputs are low.
- R2: A write of 1 to the arm bit takes effect at the next clock edge from any status. After that edge the arm bit reads 1 and the status reads 1. A write during counting abandons that count.
- R3: With status 1 and the arm bit set, the first falling edge of the synchronised line moves the status to 2. A line that is already low when the meter is armed does not start a count until it rises and falls again.
- R4: The stored count equals the number of clock cycles for which the line was low. It is updated only when a measurement completes, and it appears SYNC_STAGES+1 clock edges after the line rises.
- R5: On completion the status returns to 1, the arm bit clears itself and the completion flag is set.
- R6: The running count saturates at 2^CNT_W-1 and does not wrap.
- R7: Clearing the arm bit while the status is 2 does not cancel the measurement, and it still completes. Clearing the arm bit while the status is 1 makes later falling edges have no effect.
- R8: `irq_o` is high exactly when the completion flag and `irq_en_i` are both set. A pulse on `irq_clr_i` clears the flag. A completion in the same cycle as a clear pulse wins over the clear.
- R9: `rx_grp_irq_o` is the OR of `irq_o` and `rx_other_irq_i`.
- R10: The status never takes the code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; its cycles are what the meter counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| arm_wr_i | input | 1 | One-cycle write strobe for the arm bit |
| arm_val_i | input | 1 | Value written to the arm bit when `arm_wr_i` is high |
| irq_en_i | input | 1 | Enables the completion interrupt |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the completion flag |
| rx_other_irq_i | input | 1 | Other receive-related interrupt sources |
| arm_o | output | 1 | Current arm bit |
| status_o | output | 2 | 0 not initialised, 1 ready, 2 counting |
| count_o | output | CNT_W | Stored width of the last completed measurement |
| irq_flag_o | output | 1 | Completion flag |
| irq_o | output | 1 | Completion interrupt (flag and enable) |
| rx_grp_irq_o | output | 1 | Completion interrupt merged with the other receive interrupts |

## Verification
Each result is due at a fixed number of clock edges after its stimulus:

- An arm write is visible one edge after the strobe.
- The counting status appears SYNC_STAGES+1 edges after the line falls.
- The stored count, the ready status, the cleared arm bit and the flag appear SYNC_STAGES+1 edges after the line rises.

The bench drives inputs on falling clock edges and samples half a cycle after the edge in question. At SYNC_STAGES edges after the rise it confirms that the status still reads counting. One edge later it checks the finished result, so a latency that is off by one edge in either direction is caught. Pulse widths are swept from 1 to 40 cycles and through the saturation boundary of an 8-bit counter. The expected count is the pulse width itself, capped at 255.

// File: rtl/abr_pkg.sv
package abr_pkg;
   typedef enum logic [1:0] {
      ST_NOT_INIT = 2'd0,
      ST_READY    = 2'd1,
      ST_COUNTING = 2'd2
   } abr_state_e;
endpackage

// File: rtl/abr_rx_sync.sv
module abr_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic fall_o,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("abr_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], rx_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign fall_o = prev_q & ~chain_q[STAGES-1];
   assign rise_o = ~prev_q & chain_q[STAGES-1];
endmodule

// File: rtl/abr_width_ctr.sv
module abr_width_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_one_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (load_one_i)
         cnt_o <= CNT_ONE;
      else if (inc_i && cnt_o != CNT_MAX)
         cnt_o <= cnt_o + CNT_ONE;
   end
endmodule

// File: rtl/abr_ctrl.sv
module abr_ctrl
   import abr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_wr_i,
   input  logic             arm_val_i,
   input  logic             irq_clr_i,
   input  logic             fall_i,
   input  logic             rise_i,
   input  logic [CNT_W-1:0] run_cnt_i,
   output logic             load_one_o,
   output logic             inc_o,
   output logic             arm_o,
   output abr_state_e       state_o,
   output logic [CNT_W-1:0] result_o,
   output logic             flag_o
);
   logic set_arm, clr_arm, begin_cnt, done;

   assign set_arm   = arm_wr_i & arm_val_i;
   assign clr_arm   = arm_wr_i & ~arm_val_i;
   assign begin_cnt = ~set_arm & (state_o == ST_READY) & arm_o & fall_i;
   assign done      = ~set_arm & (state_o == ST_COUNTING) & rise_i;

   assign load_one_o = begin_cnt;
   assign inc_o      = (state_o == ST_COUNTING) & ~rise_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o  <= ST_NOT_INIT;
         arm_o    <= 1'b0;
         result_o <= '0;
         flag_o   <= 1'b0;
      end else begin
         if (set_arm) begin
            state_o <= ST_READY;
            arm_o   <= 1'b1;
         end else begin
            if (clr_arm || done)
               arm_o <= 1'b0;
            if (begin_cnt)
               state_o <= ST_COUNTING;
            else if (done)
               state_o <= ST_READY;
         end
         if (done)
            result_o <= run_cnt_i;
         if (done)
            flag_o <= 1'b1;
         else if (irq_clr_i)
            flag_o <= 1'b0;
      end
   end
endmodule

// File: rtl/abr_meas_unit.sv
module abr_meas_unit
   import abr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_i,
   input  logic             arm_wr_i,
   input  logic             arm_val_i,
   input  logic             irq_en_i,
   input  logic             irq_clr_i,
   input  logic             rx_other_irq_i,
   output logic             arm_o,
   output logic [1:0]       status_o,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_flag_o,
   output logic             irq_o,
   output logic             rx_grp_irq_o
);
   generate
      if (CNT_W < 4 || CNT_W > 32) begin : g_bad_width
         $error("abr_meas_unit: CNT_W must lie in 4..32");
      end
   endgenerate

   logic             fall, rise, load_one, inc;
   logic [CNT_W-1:0] run_cnt;
   abr_state_e       state;

   abr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .fall_o(fall), .rise_o(rise)
   );

   abr_width_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load_one_i(load_one), .inc_i(inc),
      .cnt_o(run_cnt)
   );

   abr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .arm_wr_i(arm_wr_i), .arm_val_i(arm_val_i),
      .irq_clr_i(irq_clr_i), .fall_i(fall), .rise_i(rise),
      .run_cnt_i(run_cnt), .load_one_o(load_one), .inc_o(inc),
      .arm_o(arm_o), .state_o(state), .result_o(count_o), .flag_o(irq_flag_o)
   );

   assign status_o     = state;
   assign irq_o        = irq_flag_o & irq_en_i;
   assign rx_grp_irq_o = irq_o | rx_other_irq_i;
endmodule

// File: rtl/abr_meas_chk.sv
module abr_meas_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm_wr_i,
   input logic             arm_val_i,
   input logic             irq_clr_i,
   input logic             arm_o,
   input logic [1:0]       status_o,
   input logic [CNT_W-1:0] count_o,
   input logic             irq_flag_o
);
   p_status_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      status_o != 2'd3);

   p_arm_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_wr_i && arm_val_i) |=> (status_o == 2'd1 && arm_o));

   p_done_effects_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 2'd2 && !(arm_wr_i && arm_val_i))
      |=> (status_o != 2'd1 || (irq_flag_o && !arm_o)));

   p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o != 2'd2) |=> $stable(count_o));

   p_disarmed_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o == 2'd1 && !arm_o && !(arm_wr_i && arm_val_i))
      |=> status_o == 2'd1);

   p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag_o && !irq_clr_i) |=> irq_flag_o);

   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag_o && irq_clr_i && status_o != 2'd2) |=> !irq_flag_o);
endmodule

bind abr_meas_unit abr_meas_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .arm_wr_i(arm_wr_i), .arm_val_i(arm_val_i),
   .irq_clr_i(irq_clr_i), .arm_o(arm_o), .status_o(status_o),
   .count_o(count_o), .irq_flag_o(irq_flag_o)
);

// File: tb/sim_abr_meas_unit.sv
module sim_abr_meas_unit;
   localparam int CW   = 8;
   localparam int SYNC = 2;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1, arm_wr = 1'b0, arm_val = 1'b0, ien = 1'b0, iclr = 1'b0, oth = 1'b0;
   logic arm;
   logic [1:0] st;
   logic [CW-1:0] cnt;
   logic flag, irq, grp;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   abr_meas_unit #(.CNT_W(CW), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .arm_wr_i(arm_wr), .arm_val_i(arm_val),
      .irq_en_i(ien), .irq_clr_i(iclr), .rx_other_irq_i(oth),
      .arm_o(arm), .status_o(st), .count_o(cnt), .irq_flag_o(flag),
      .irq_o(irq), .rx_grp_irq_o(grp)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_arm(input logic v);
      arm_wr = 1'b1; arm_val = v;
      cyc(1);
      arm_wr = 1'b0; arm_val = 1'b0;
   endtask

   task automatic clear_flag();
      iclr = 1'b1; cyc(1); iclr = 1'b0;
   endtask

   // Full measurement of a low pulse of w cycles
   task automatic measure(input int w);
      int exp;
      exp = (w > CMAX) ? CMAX : w;
      write_arm(1'b1);
      chk(st == 2'd1 && arm, "R2 armed", st, 1);
      cyc(2);
      rx = 1'b0;
      cyc(w);
      rx = 1'b1;
      cyc(SYNC);
      chk(st == 2'd2, "R3 still counting before due edge", st, 2);
      cyc(1);
      chk(st == 2'd1, "R5 status ready after completion", st, 1);
      chk(!arm, "R5 arm self-clear", arm, 0);
      chk(flag, "R5 flag set", flag, 1);
      chk(cnt == CW'(exp), (w > CMAX) ? "R6 saturated count" : "R4 count width", cnt, exp);
      clear_flag();
      chk(!flag, "R8 flag cleared", flag, 0);
      cyc(2);
   endtask

   initial begin
      cyc(3);
      chk(st == 2'd0, "R1 status", st, 0);
      chk(!arm && cnt == 0 && !flag && !irq && !grp, "R1 outputs", {arm, flag, irq, grp}, 0);
      rst_n = 1'b1;
      cyc(2);
      chk(st == 2'd0, "R1 status after release", st, 0);

      // clearing arm from not-initialised keeps status 0
      write_arm(1'b0);
      chk(st == 2'd0 && !arm, "R2 clear write no arm", st, 0);

      // sweep of widths
      for (int w = 1; w <= 40; w++) measure(w);
      measure(100);
      measure(CMAX - 1);
      measure(CMAX);
      measure(CMAX + 1);
      measure(300);

      // counting status timing
      write_arm(1'b1);
      rx = 1'b0;
      cyc(SYNC);
      chk(st == 2'd1, "R3 not yet counting", st, 1);
      cyc(1);
      chk(st == 2'd2, "R3 counting after fall", st, 2);
      // R7: clear arm during counting, must still complete
      write_arm(1'b0);
      chk(st == 2'd2 && !arm, "R7 counting survives disarm", st, 2);
      cyc(6);
      rx = 1'b1;
      cyc(SYNC + 1);
      chk(st == 2'd1 && flag, "R7 completion after disarm", flag, 1);
      chk(cnt == CW'(10), "R7 count after disarm", cnt, 10);

      // R8 interrupt gating and R9 group output
      ien = 1'b0; #1;
      chk(!irq && !grp, "R8 irq masked", irq, 0);
      ien = 1'b1; #1;
      chk(irq && grp, "R8 irq enabled", irq, 1);
      ien = 1'b0; oth = 1'b1; #1;
      chk(!irq && grp, "R9 other source", grp, 1);
      oth = 1'b0; #1;
      chk(!grp, "R9 group idle", grp, 0);
      ien = 1'b1;
      clear_flag();
      chk(!flag && !irq, "R8 clear", irq, 0);

      // R7: disarmed while ready ignores falling edges
      write_arm(1'b1);
      write_arm(1'b0);
      rx = 1'b0; cyc(8); rx = 1'b1; cyc(6);
      chk(st == 2'd1 && !flag, "R7 ignored fall when disarmed", st, 1);
      chk(cnt == CW'(10), "R7 count untouched", cnt, 10);

      // R3: line low at arm time does not count until it rises and falls
      rx = 1'b0; cyc(4);
      write_arm(1'b1);
      cyc(5);
      chk(st == 2'd1, "R3 low line at arm ignored", st, 1);
      rx = 1'b1; cyc(4);
      chk(st == 2'd1 && !flag, "R3 rise alone ignored", st, 1);
      rx = 1'b0; cyc(7); rx = 1'b1; cyc(SYNC + 1);
      chk(cnt == CW'(7) && flag, "R3 R4 later pulse measured", cnt, 7);
      clear_flag();

      // R2: re-arm during counting abandons count
      write_arm(1'b1);
      rx = 1'b0; cyc(20);
      chk(st == 2'd2, "R2 counting before re-arm", st, 2);
      write_arm(1'b1);
      chk(st == 2'd1 && arm, "R2 re-arm to ready", st, 1);
      rx = 1'b1; cyc(6);
      chk(st == 2'd1 && !flag && cnt == CW'(7), "R2 abandoned count", cnt, 7);
      rx = 1'b0; cyc(5); rx = 1'b1; cyc(SYNC + 1);
      chk(cnt == CW'(5) && flag, "R2 fresh count after re-arm", cnt, 5);

      // R8: completion wins over simultaneous clear
      write_arm(1'b1);
      rx = 1'b0; cyc(4); rx = 1'b1;
      cyc(SYNC);
      iclr = 1'b1; cyc(1); iclr = 1'b0;
      chk(flag && cnt == CW'(4), "R8 set wins over clear", flag, 1);
      chk(st != 2'd3, "R10 legal status", st, 2);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule